// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the processor core may run, when it must stop, and how it comes back. It handles two kinds of low-power state. In power-down the core clock stops and, as an option, the oscillator stops too. In idle the core halts until an interrupt arrives, or runs at a reduced rate. A hardware pin or a software force bit asks for power-down. The sequencer first lets the current instruction finish. It then gates the core clock and raises an acknowledge.

A wake event starts a count of input-clock cycles. The length of the count depends on whether the oscillator was stopped: a short delay when it kept running, a long stabilisation delay when it did not. When the count ends, the core clock comes back. If the keep-context option was clear when power-down began, a one-cycle context-clear pulse goes out at the same moment.

An idle command either halts the core or, in its slow form, lets one clock-enable cycle through every N input cycles. N is 16, 32, 64 or 128, chosen by a two-bit code. A pending unmasked interrupt ends either form of idle. Requests for stolen DMA cycles pass through to an allow output in every state where the clock is alive.

Top module: `lpm_seq`

## Requirements
- R1: After reset, core_clk_en=1, pd_ack=0, osc_en=1, slow_idle=0 and ctx_clear=0.
- R2: When pd_pin or pd_force is high in the run state, core_clk_en stays high until insn_done is sampled high. From the next edge, core_clk_en=0 and pd_ack=1 together.
- R3: During power-down, osc_en=0 if osc_off_cfg was high at the edge that entered power-down; otherwise osc_en=1.
- R4: With the oscillator kept running, pd_ack falls at the edge that samples wake_req. core_clk_en returns exactly FAST_WAKE (default 200) edges later.
- R5: With the oscillator stopped, osc_en rises at the edge that samples wake_req. core_clk_en returns exactly SLOW_WAKE (default 4096) edges later.
- R6: ctx_clear is a one-cycle pulse in the first cycle the core clock is back after power-down, only if keep_ctx_cfg was low when power-down was entered.
- R7: Asserting rst_n low during power-down returns the outputs at once to the values of R1.
- R8: idle_req with idle_slow=0 makes core_clk_en 0 from the next edge. core_clk_en returns to 1 at the edge that samples irq_pend.
- R9: idle_req with idle_slow=1 gives a one-cycle core_clk_en pulse every 16<<idle_div input cycles (code 0..3 = 16, 32, 64, 128). The first pulse falls in the Nth cycle of slow idle. slow_idle is 1 throughout. Full rate (core_clk_en=1, slow_idle=0) returns at the edge that samples irq_pend.
- R10: dma_allow equals dma_req in run, drain, idle and slow idle, and is 0 during power-down and the wake count.
- R11: A power-down request and an idle command in the same cycle lead to the drain, not to idle.
- R12: wake_req has no effect outside power-down; in idle, core_clk_en stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, always running at the block |
| rst_n | input | 1 | Asynchronous active-low reset; also ends power-down |
| pd_pin | input | 1 | Power-down request from the pin |
| pd_force | input | 1 | Software power-down force bit |
| wake_req | input | 1 | Wake event while powered down |
| osc_off_cfg | input | 1 | Stop the oscillator during power-down |
| keep_ctx_cfg | input | 1 | 1 = resume with context, 0 = clear context on exit |
| idle_req | input | 1 | Idle command strobe |
| idle_slow | input | 1 | Idle command selects the divided-clock form |
| idle_div | input | 2 | Divisor code: N = 16 << code |
| irq_pend | input | 1 | Pending unmasked interrupt |
| insn_done | input | 1 | Core has completed its current instruction |
| dma_req | input | 1 | Request for a stolen DMA cycle |
| core_clk_en | output | 1 | Core clock enable |
| slow_idle | output | 1 | Core is running at the divided rate |
| pd_ack | output | 1 | Power-down reached |
| osc_en | output | 1 | Oscillator enable |
| ctx_clear | output | 1 | One-cycle context-clear pulse on wake |
| dma_allow | output | 1 | Stolen DMA cycle granted |

## Verification
The long wake with the oscillator stopped is the hardest case to reach. It needs a full entry through the drain with osc_off_cfg set, then a wake count of 4096 cycles whose final edge must be found exactly. The stimulus raises the force bit together with insn_done, so the drain is left on the next edge. The scoreboard places expectations one edge before and one edge after the terminal count, so a count off by one cycle in either direction is seen. The same pass checks the context-clear pulse, with keep_ctx_cfg low, in the cycle the clock returns and the cycle after it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_PDOWN = 3'd2,
        ST_WAKE  = 3'd3,
        ST_IDLE  = 3'd4,
        ST_SLOW  = 3'd5
    } lpm_state_e;

    typedef struct packed {
        lpm_state_e st;
        logic       osc_off;
        logic       keep;
        logic       ctx;
    } lpm_regs_t;

endpackage

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int unsigned FAST_WAKE = 200,
    parameter int unsigned SLOW_WAKE = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic long_sel,
    output logic done
);
    localparam int unsigned MAXW = (SLOW_WAKE > FAST_WAKE) ? SLOW_WAKE : FAST_WAKE;
    localparam int CW = (MAXW > 2) ? $clog2(MAXW) : 1;
    localparam logic [CW-1:0] FAST_TERM = CW'(FAST_WAKE - 1);
    localparam logic [CW-1:0] SLOW_TERM = CW'(SLOW_WAKE - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] term;

    always_comb begin
        term  = long_sel ? SLOW_TERM : FAST_TERM;
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (active && cnt_q != term) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = active && (cnt_q == term);

endmodule

// File: rtl/lpm_slow_div.sv
module lpm_slow_div #(
    parameter int DIV_BASE_LOG = 4,
    parameter int DIV_CODE_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  active,
    input  logic [DIV_CODE_W-1:0] code,
    output logic                  tick
);
    localparam int DW = DIV_BASE_LOG + (1 << DIV_CODE_W) - 1;
    localparam logic [DW:0] ONE_W = (DW+1)'(1);

    typedef struct packed {
        logic [DW-1:0]         cnt;
        logic [DIV_CODE_W-1:0] code;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [DW:0]   span;
    logic [DW:0]   lim_w;
    logic [DW-1:0] lim;

    always_comb begin
        span  = ONE_W << (DIV_BASE_LOG + int'(r_q.code));
        lim_w = span - ONE_W;
        lim   = lim_w[DW-1:0];
        r_d   = r_q;
        if (start) begin
            r_d.cnt  = '0;
            r_d.code = code;
        end else if (active) begin
            r_d.cnt = (r_q.cnt == lim) ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = active && (r_q.cnt == lim);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int unsigned FAST_WAKE    = 200,
    parameter int unsigned SLOW_WAKE    = 4096,
    parameter int          DIV_BASE_LOG = 4,
    parameter int          DIV_CODE_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_pin,
    input  logic                  pd_force,
    input  logic                  wake_req,
    input  logic                  osc_off_cfg,
    input  logic                  keep_ctx_cfg,
    input  logic                  idle_req,
    input  logic                  idle_slow,
    input  logic [DIV_CODE_W-1:0] idle_div,
    input  logic                  irq_pend,
    input  logic                  insn_done,
    input  logic                  dma_req,
    output logic                  core_clk_en,
    output logic                  slow_idle,
    output logic                  pd_ack,
    output logic                  osc_en,
    output logic                  ctx_clear,
    output logic                  dma_allow
);
    localparam lpm_regs_t RESET_REGS = '{st: ST_RUN, osc_off: 1'b0, keep: 1'b1, ctx: 1'b0};

    lpm_regs_t r_d, r_q;
    logic pd_req;
    logic wake_start;
    logic slow_start;
    logic wake_done;
    logic div_tick;

    assign pd_req     = pd_pin | pd_force;
    assign wake_start = (r_q.st == ST_PDOWN) && wake_req;
    assign slow_start = (r_q.st == ST_RUN) && !pd_req && idle_req && idle_slow;

    lpm_wake_timer #(
        .FAST_WAKE (FAST_WAKE),
        .SLOW_WAKE (SLOW_WAKE)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wake_start),
        .active   (r_q.st == ST_WAKE),
        .long_sel (r_q.osc_off),
        .done     (wake_done)
    );

    lpm_slow_div #(
        .DIV_BASE_LOG (DIV_BASE_LOG),
        .DIV_CODE_W   (DIV_CODE_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (slow_start),
        .active (r_q.st == ST_SLOW),
        .code   (idle_div),
        .tick   (div_tick)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ctx = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (pd_req) begin
                    r_d.st = ST_DRAIN;
                end else if (idle_req) begin
                    r_d.st = idle_slow ? ST_SLOW : ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (insn_done) begin
                    r_d.st      = ST_PDOWN;
                    r_d.osc_off = osc_off_cfg;
                    r_d.keep    = keep_ctx_cfg;
                end
            end
            ST_PDOWN: begin
                if (wake_req) r_d.st = ST_WAKE;
            end
            ST_WAKE: begin
                if (wake_done) begin
                    r_d.st  = ST_RUN;
                    r_d.ctx = !r_q.keep;
                end
            end
            ST_IDLE, ST_SLOW: begin
                if (irq_pend) r_d.st = ST_RUN;
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    always_comb begin
        core_clk_en = 1'b0;
        dma_allow   = 1'b0;
        unique case (r_q.st)
            ST_RUN, ST_DRAIN: begin
                core_clk_en = 1'b1;
                dma_allow   = dma_req;
            end
            ST_IDLE: dma_allow = dma_req;
            ST_SLOW: begin
                core_clk_en = div_tick;
                dma_allow   = dma_req;
            end
            default: begin
                core_clk_en = 1'b0;
                dma_allow   = 1'b0;
            end
        endcase
    end

    assign slow_idle = (r_q.st == ST_SLOW);
    assign pd_ack    = (r_q.st == ST_PDOWN);
    assign osc_en    = !((r_q.st == ST_PDOWN) && r_q.osc_off);
    assign ctx_clear = r_q.ctx;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic insn_done,
    input logic dma_req,
    input logic core_clk_en,
    input logic slow_idle,
    input logic pd_ack,
    input logic osc_en,
    input logic ctx_clear,
    input logic dma_allow
);
    // R2
    ack_stops_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_ack |-> !core_clk_en);

    // R2
    ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_ack) |-> $past(insn_done));

    // R3
    osc_only_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> pd_ack);

    // R5
    osc_on_at_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_ack) |-> osc_en);

    // R6
    ctx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |=> !ctx_clear);

    // R6
    ctx_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |-> (core_clk_en && $past(!core_clk_en)));

    // R9
    slow_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_idle && core_clk_en) |=> !core_clk_en);

    // R10
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_allow |-> (dma_req && !pd_ack));

endmodule

bind lpm_seq lpm_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done   (insn_done),
    .dma_req     (dma_req),
    .core_clk_en (core_clk_en),
    .slow_idle   (slow_idle),
    .pd_ack      (pd_ack),
    .osc_en      (osc_en),
    .ctx_clear   (ctx_clear),
    .dma_allow   (dma_allow)
);

// File: tb/lpm_seq_test.sv
module lpm_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int FAST = 200;
    localparam int SLOW = 4096;

    // output vector bit order: core, slow, ack, osc, ctx, dma
    localparam logic [5:0] M_CORE = 6'b100000;
    localparam logic [5:0] M_SLOW = 6'b010000;
    localparam logic [5:0] M_ACK  = 6'b001000;
    localparam logic [5:0] M_OSC  = 6'b000100;
    localparam logic [5:0] M_CTX  = 6'b000010;
    localparam logic [5:0] M_DMA  = 6'b000001;

    typedef struct {
        int         cyc;
        logic [5:0] m;
        logic [5:0] v;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pin = 0, pd_force = 0, wake_req = 0, osc_off_cfg = 0, keep_ctx_cfg = 1;
    logic idle_req = 0, idle_slow = 0, irq_pend = 0, insn_done = 0, dma_req = 0;
    logic [1:0] idle_div = 2'd0;
    logic core_clk_en, slow_idle, pd_ack, osc_en, ctx_clear, dma_allow;
    logic [5:0] outs;

    int cyc = 0;
    int checks = 0;
    int errs = 0;
    bit done = 0;
    exp_t sb[$];

    lpm_seq uut (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .pd_force(pd_force),
        .wake_req(wake_req), .osc_off_cfg(osc_off_cfg), .keep_ctx_cfg(keep_ctx_cfg),
        .idle_req(idle_req), .idle_slow(idle_slow), .idle_div(idle_div),
        .irq_pend(irq_pend), .insn_done(insn_done), .dma_req(dma_req),
        .core_clk_en(core_clk_en), .slow_idle(slow_idle), .pd_ack(pd_ack),
        .osc_en(osc_en), .ctx_clear(ctx_clear), .dma_allow(dma_allow)
    );

    assign outs = {core_clk_en, slow_idle, pd_ack, osc_en, ctx_clear, dma_allow};

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops every expectation due in the current cycle
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < sb.size()) begin
            if (sb[i].cyc == cyc) begin
                checks++;
                if ((outs & sb[i].m) !== (sb[i].v & sb[i].m)) begin
                    errs++;
                    $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                             sb[i].tag, cyc, outs & sb[i].m, sb[i].v & sb[i].m, sb[i].m);
                end
                sb.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic expect_at(input int d, input logic [5:0] m, input logic [5:0] v, input string tag);
        exp_t e;
        e.cyc = cyc + d;
        e.m   = m;
        e.v   = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1: reset values
        expect_at(0, 6'b111111, M_CORE | M_OSC, "R1");
        step(2);

        // R2/R3/R4: pin request, oscillator kept, context kept
        osc_off_cfg = 0; keep_ctx_cfg = 1; pd_pin = 1;
        expect_at(1, M_CORE | M_ACK, M_CORE, "R2 drain");
        step(4);
        expect_at(0, M_CORE | M_ACK, M_CORE, "R2 waits for insn_done");
        insn_done = 1;
        expect_at(1, M_CORE | M_ACK | M_OSC, M_ACK | M_OSC, "R2 R3 clock off, ack, osc kept");
        step(1);
        insn_done = 0; pd_pin = 0; dma_req = 1;
        expect_at(1, M_DMA, 6'b0, "R10 dma blocked in power-down");
        step(5);
        wake_req = 1;
        expect_at(1, M_ACK | M_CORE | M_OSC, M_OSC, "R4 ack falls on wake");
        expect_at(FAST, M_CORE, 6'b0, "R4 still waking");
        expect_at(FAST + 1, M_CORE | M_CTX | M_DMA, M_CORE | M_DMA, "R4 R6 R10 clock back, no clear");
        step(1);
        wake_req = 0;
        step(FAST + 4);
        dma_req = 0;

        // R3/R5/R6: force bit, oscillator stopped, context cleared
        osc_off_cfg = 1; keep_ctx_cfg = 0; pd_force = 1; insn_done = 1;
        expect_at(1, M_CORE | M_ACK, M_CORE, "R2 force enters drain");
        expect_at(2, M_CORE | M_ACK | M_OSC, M_ACK, "R3 osc stopped");
        step(1);
        pd_force = 0;
        step(4);
        insn_done = 0; osc_off_cfg = 0; keep_ctx_cfg = 1;
        wake_req = 1;
        expect_at(1, M_OSC | M_ACK | M_CORE, M_OSC, "R5 osc on at wake");
        expect_at(SLOW, M_CORE, 6'b0, "R5 still stabilising");
        expect_at(SLOW + 1, M_CORE | M_CTX, M_CORE | M_CTX, "R5 R6 clock back with clear");
        expect_at(SLOW + 2, M_CTX, 6'b0, "R6 clear is one cycle");
        step(1);
        wake_req = 0;
        step(SLOW + 4);

        // R7: reset ends power-down
        osc_off_cfg = 1; pd_pin = 1; insn_done = 1;
        step(3);
        expect_at(0, M_ACK | M_OSC, M_ACK, "R7 in power-down");
        step(1);
        pd_pin = 0; insn_done = 0; osc_off_cfg = 0;
        rst_n = 0;
        expect_at(0, M_CORE | M_ACK | M_OSC | M_SLOW | M_CTX, M_CORE | M_OSC, "R7 reset wakes");
        step(2);
        rst_n = 1;
        step(2);

        // R8/R10/R12: plain idle
        idle_req = 1; idle_slow = 0;
        expect_at(1, M_CORE | M_SLOW, 6'b0, "R8 idle halts");
        step(1);
        idle_req = 0; dma_req = 1;
        expect_at(1, M_DMA, M_DMA, "R10 dma in idle");
        step(5);
        wake_req = 1;
        expect_at(1, M_CORE | M_ACK, 6'b0, "R12 wake ignored in idle");
        step(1);
        wake_req = 0; dma_req = 0; irq_pend = 1;
        expect_at(1, M_CORE, M_CORE, "R8 irq resumes");
        step(1);
        irq_pend = 0;
        step(2);

        // R9: slow idle at every code
        for (int k = 0; k < 4; k++) begin
            int n;
            n = 16 << k;
            idle_req = 1; idle_slow = 1; idle_div = 2'(k);
            expect_at(1, M_CORE | M_SLOW, M_SLOW, "R9 slow idle entered");
            expect_at(n - 1, M_CORE, 6'b0, "R9 before first pulse");
            expect_at(n, M_CORE | M_SLOW, M_CORE | M_SLOW, "R9 first pulse");
            expect_at(n + 1, M_CORE, 6'b0, "R9 pulse is one cycle");
            expect_at(2 * n, M_CORE, M_CORE, "R9 second pulse");
            step(1);
            idle_req = 0; idle_slow = 0;
            step(2 * n + 2);
            irq_pend = 1;
            expect_at(1, M_CORE | M_SLOW, M_CORE, "R9 full rate after irq");
            step(1);
            irq_pend = 0;
            step(2);
        end

        // R11: power-down beats idle
        osc_off_cfg = 0; keep_ctx_cfg = 1;
        pd_pin = 1; idle_req = 1; idle_slow = 0;
        expect_at(1, M_CORE | M_SLOW | M_ACK, M_CORE, "R11 drain not idle");
        step(1);
        idle_req = 0; insn_done = 1;
        expect_at(1, M_ACK, M_ACK, "R11 power-down reached");
        step(1);
        pd_pin = 0; insn_done = 0; wake_req = 1;
        step(1);
        wake_req = 0;
        step(FAST + 4);
        expect_at(0, M_CORE | M_ACK, M_CORE, "R4 back to run");
        step(2);

        done = 1;
        finish_run();
    end

endmodule